// File: doc/BRIEF.md
# Stream-to-Memory DMA Engine

This block moves a run of data words between a word-addressed memory and a pair of valid/ready streaming ports. The memory is reached through a plain request/acknowledge master port. A processor sets the engine up through a small register-mapped slave port. It programs a byte start address, a length counted in words and a direction, and then writes a start bit. The engine then runs the transfer on its own. Each word costs one memory access and one stream handshake.

There are two directions. In memory-to-stream mode, each word is read from memory, held in a register and offered on the outgoing stream until the consumer takes it. In stream-to-memory mode, a word is taken from the incoming stream only when no memory write is pending, and it is then written back. When the run ends, software sees a done flag in the status register. If enabled, a level interrupt also rises. Software clears it by writing a one to the done bit.

Top module: `dma_stream_engine`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `mem_req`, `tx_valid` and `rx_ready` are low.
- R2: Register map at `cfg_addr`:
  - 0x0 is control: bit0 start (reads 0), bit1 direction (0 = memory to stream, 1 = stream to memory), bit2 interrupt enable.
  - 0x4 is status: bit0 busy, bit1 done.
  - 0x8 is the byte address of the next word.
  - 0xC is the remaining length in words.
  - The address, length, direction and enable fields read back what was written.
- R3: A transfer starts only on a control write with bit0 set while idle and with a nonzero length. Busy reads 1 from the next cycle. While idle, no memory request and no stream activity occur.
- R4: Memory to stream: each word is read from consecutive addresses and offered on `tx_data`. `tx_valid`, `tx_data` and `tx_last` stay steady until `tx_ready`. `tx_last` is high on the final word only.
- R5: Stream to memory: `rx_ready` is high only while no memory write is pending. Accepted words are written to consecutive addresses in arrival order.
- R6: At most one memory request is open at a time. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. A transfer of N words makes exactly N memory accesses.
- R7: The address register advances by 4 and the length register drops by 1 per completed word. After a run of N words from base B they read B+4N and 0.
- R8: On the final word, busy clears and done sets in the same cycle. Busy and done are never both 1.
- R9: A start with length 0 sets done on the next cycle, leaves busy 0 and makes no memory access.
- R10: While busy, writes to control, address and length are ignored. A second start does not change the running transfer or its direction.
- R11: Writing status with bit1 = 1 clears done. Writing status with bit1 = 0 leaves done unchanged.
- R12: `irq` is high exactly while done and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access completes this cycle; read data valid |
| mem_rdata | input | DATA_W | Read data |
| tx_valid | output | 1 | Outgoing stream word valid |
| tx_ready | input | 1 | Outgoing stream consumer ready |
| tx_data | output | DATA_W | Outgoing stream word |
| tx_last | output | 1 | Marks the final word of a run |
| rx_valid | input | 1 | Incoming stream word valid |
| rx_ready | output | 1 | Engine can take an incoming word |
| rx_data | input | DATA_W | Incoming stream word |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The bench runs both directions over several lengths and bases. In some runs, the memory acknowledge, the consumer's ready or the producer's valid stall at random.

- Zero-stall runs show the address and length counting and the placement of the last flag.
- Stalled memory acknowledge shows that a pending write really holds off `rx_ready`.
- Stalled `tx_ready` shows that data is held, and it gives a long window in which to check that a second start and register writes during a busy run are ignored.
- Single-word and zero-length runs separate the first-word, last-word and no-work edge cases.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int CFG_W  = 32;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
    localparam logic [REG_AW-1:0] OFS_STAT = 4'h4;
    localparam logic [REG_AW-1:0] OFS_ADDR = 4'h8;
    localparam logic [REG_AW-1:0] OFS_LEN  = 4'hC;

    localparam int BIT_START = 0;
    localparam int BIT_DIR   = 1;
    localparam int BIT_IE    = 2;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_DONE  = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD,
        SQ_TX,
        SQ_RX,
        SQ_WR
    } seq_state_e;

    typedef enum logic {
        DIR_M2S = 1'b0,
        DIR_S2M = 1'b1
    } dir_e;

    typedef struct packed {
        logic irq_en;
        dir_e dir;
    } ctrl_t;

    function automatic logic is_write(input logic we, input logic [REG_AW-1:0] a,
                                      input logic [REG_AW-1:0] ofs);
        return we && (a == ofs);
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              beat,
    input  logic              finish,
    output logic              start_go,
    output dir_e              start_dir,
    output logic              last_beat,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done,
    output logic              irq
);
    localparam int BYTES = DATA_W / 8;

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              done_q;
    logic              wr_ctrl, wr_stat, wr_addr, wr_len;
    logic              unused_wbits;

    assign wr_ctrl   = is_write(cfg_we, cfg_addr, OFS_CTRL) && !busy;
    assign wr_stat   = is_write(cfg_we, cfg_addr, OFS_STAT);
    assign wr_addr   = is_write(cfg_we, cfg_addr, OFS_ADDR) && !busy;
    assign wr_len    = is_write(cfg_we, cfg_addr, OFS_LEN) && !busy;
    assign start_go  = wr_ctrl && cfg_wdata[BIT_START] && (len_q != '0);
    assign start_dir = dir_e'(cfg_wdata[BIT_DIR]);
    assign last_beat = (len_q == LEN_W'(1));
    assign cur_addr  = addr_q;
    assign done      = done_q;
    assign irq       = done_q && ctrl_q.irq_en;
    assign unused_wbits = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.irq_en <= cfg_wdata[BIT_IE];
                ctrl_q.dir    <= dir_e'(cfg_wdata[BIT_DIR]);
                if (cfg_wdata[BIT_START])
                    done_q <= (len_q == '0);
            end
            if (wr_addr)
                addr_q <= cfg_wdata[ADDR_W-1:0];
            if (wr_len)
                len_q <= cfg_wdata[LEN_W-1:0];
            if (wr_stat && cfg_wdata[BIT_DONE])
                done_q <= 1'b0;
            if (beat) begin
                addr_q <= addr_q + ADDR_W'(BYTES);
                len_q  <= len_q - LEN_W'(1);
            end
            if (finish)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_CTRL: begin
                cfg_rdata[BIT_DIR] = ctrl_q.dir;
                cfg_rdata[BIT_IE]  = ctrl_q.irq_en;
            end
            OFS_STAT: begin
                cfg_rdata[BIT_BUSY] = busy;
                cfg_rdata[BIT_DONE] = done_q;
            end
            OFS_ADDR: cfg_rdata[ADDR_W-1:0] = addr_q;
            OFS_LEN:  cfg_rdata[LEN_W-1:0]  = len_q;
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_go,
    input  dir_e              start_dir,
    input  logic              last_beat,
    output logic              busy,
    output logic              beat,
    output logic              finish,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data
);
    seq_state_e        state_q;
    logic [DATA_W-1:0] hold_q;

    assign busy      = (state_q != SQ_IDLE);
    assign mem_req   = (state_q == SQ_RD) || (state_q == SQ_WR);
    assign mem_we    = (state_q == SQ_WR);
    assign mem_wdata = hold_q;
    assign tx_valid  = (state_q == SQ_TX);
    assign tx_data   = hold_q;
    assign tx_last   = (state_q == SQ_TX) && last_beat;
    assign rx_ready  = (state_q == SQ_RX);
    assign beat      = ((state_q == SQ_TX) && tx_ready) || ((state_q == SQ_WR) && mem_ack);
    assign finish    = beat && last_beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            hold_q  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start_go)
                    state_q <= (start_dir == DIR_S2M) ? SQ_RX : SQ_RD;
                SQ_RD: if (mem_ack) begin
                    hold_q  <= mem_rdata;
                    state_q <= SQ_TX;
                end
                SQ_TX: if (tx_ready)
                    state_q <= last_beat ? SQ_IDLE : SQ_RD;
                SQ_RX: if (rx_valid) begin
                    hold_q  <= rx_data;
                    state_q <= SQ_WR;
                end
                SQ_WR: if (mem_ack)
                    state_q <= last_beat ? SQ_IDLE : SQ_RX;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    logic busy, beat, finish, start_go, last_beat, done;
    dir_e start_dir;

    dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .busy(busy), .beat(beat), .finish(finish),
        .start_go(start_go), .start_dir(start_dir), .last_beat(last_beat),
        .cur_addr(mem_addr), .done(done), .irq(irq)
    );

    dma_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst),
        .start_go(start_go), .start_dir(start_dir), .last_beat(last_beat),
        .busy(busy), .beat(beat), .finish(finish),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

endmodule

// File: rtl/dma_stream_engine_chk.sv
module dma_stream_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              irq,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_last,
    input logic              rx_ready
);
    // R6: an open request keeps its attributes until acknowledged
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R4: an offered word stays put until taken
    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R5: no intake while a write is pending
    assert_rx_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !rx_ready);

    // R3: idle engine is silent on both sides
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !tx_valid && !rx_ready);

    // R8: busy and done exclusive
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R12: interrupt only with done
    assert_irq_needs_done_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    // R8: leaving busy without a reset means done was raised
    assert_fall_sets_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind dma_stream_engine dma_stream_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .irq(irq),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .rx_ready(rx_ready)
);

// File: tb/dma_stream_engine_test.sv
module dma_stream_engine_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = 4'h0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          tx_valid, tx_ready, tx_last;
    logic [DW-1:0] tx_data;
    logic          rx_valid, rx_ready;
    logic [DW-1:0] rx_data;
    logic          irq;

    logic [2:0]    stall = 3'b000;
    logic [7:0]    lf;
    logic [31:0]   mem [64];
    logic [31:0]   txbuf [64];
    logic          txlast [64];
    int            txcnt, rxidx, reqcnt, rxviol;
    int            tests = 0, fails = 0;
    bit            timed_out = 0;

    always #2 clk = ~clk;

    dma_stream_engine uut (.*);

    function automatic logic [31:0] memval(input int i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0101;
    endfunction

    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_ack   = mem_req & (~stall[0] | lf[0]);
    assign tx_ready  = ~stall[1] | lf[1];
    assign rx_valid  = ~stall[2] | lf[2];
    assign rx_data   = 32'h5A00_0000 + 32'(rxidx);

    always @(negedge clk) begin
        if (rst) lf <= 8'h5B;
        else     lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= memval(i);
            txcnt <= 0; rxidx <= 0; reqcnt <= 0; rxviol <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                reqcnt <= reqcnt + 1;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            end
            if (tx_valid && tx_ready) begin
                txbuf[txcnt]  <= tx_data;
                txlast[txcnt] <= tx_last;
                txcnt <= txcnt + 1;
            end
            if (rx_valid && rx_ready) rxidx <= rxidx + 1;
            if (mem_req && rx_ready) rxviol <= rxviol + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(4'h4, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    typedef struct packed {
        logic       dir;
        logic [7:0] base;
        logic [7:0] len;
        logic [2:0] stl;
        logic [7:0] end_addr;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 8'h00, 8'd4, 3'b000, 8'h10},
        '{1'b0, 8'h20, 8'd7, 3'b011, 8'h3C},
        '{1'b1, 8'h80, 8'd5, 3'b000, 8'h94},
        '{1'b1, 8'hA0, 8'd6, 3'b101, 8'hB8},
        '{1'b0, 8'h40, 8'd1, 3'b010, 8'h44},
        '{1'b1, 8'hC0, 8'd1, 3'b100, 8'hC4}
    };

    task automatic main_tests();
        logic [31:0] v;
        int t0, r0, q0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 irq", 32'(irq), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 rx_ready", 32'(rx_ready), 0);

        // R2: readback of programmed fields
        wr(4'h8, 32'h0000_1234); rd(4'h8, v); check("R2 addr readback", v, 32'h1234);
        wr(4'hC, 32'h0000_0009); rd(4'hC, v); check("R2 len readback", v, 32'h9);
        wr(4'h0, 32'h0000_0006); rd(4'h0, v); check("R2 ctrl readback", v, 32'h6);
        rd(4'h4, v); check("R3 no start without bit0", v, 32'h0);

        // vector table: R4 R5 R6 R7 R8 R12 R11
        for (int k = 0; k < 6; k++) begin
            stall = VEC[k].stl;
            wr(4'h8, 32'(VEC[k].base));
            wr(4'hC, 32'(VEC[k].len));
            t0 = txcnt; r0 = rxidx; q0 = reqcnt;
            wr(4'h0, {29'h0, 1'(k % 2), VEC[k].dir, 1'b1});
            rd(4'h4, v); check("R3 busy after start", v, 32'h1);
            wait_idle();
            rd(4'h4, v); check("R8 done, not busy", v, 32'h2);
            check("R12 irq level", 32'(irq), 32'(k % 2));
            rd(4'h8, v); check("R7 final address", v, 32'(VEC[k].end_addr));
            rd(4'hC, v); check("R7 final length", v, 32'h0);
            check("R6 one access per word", 32'(reqcnt - q0), 32'(VEC[k].len));
            if (VEC[k].dir == 1'b0) begin
                check("R4 words out", 32'(txcnt - t0), 32'(VEC[k].len));
                for (int i = 0; i < int'(VEC[k].len); i++) begin
                    check("R4 data", txbuf[t0 + i], memval(int'(VEC[k].base) / 4 + i));
                    check("R4 last flag", 32'(txlast[t0 + i]), 32'(i == int'(VEC[k].len) - 1));
                end
            end else begin
                check("R5 words in", 32'(rxidx - r0), 32'(VEC[k].len));
                for (int i = 0; i < int'(VEC[k].len); i++)
                    check("R5 memory word", mem[int'(VEC[k].base) / 4 + i], 32'h5A00_0000 + 32'(r0 + i));
                check("R5 rx_ready during write", 32'(rxviol), 0);
            end
            wr(4'h4, 32'h0); rd(4'h4, v); check("R11 zero write keeps done", v, 32'h2);
            wr(4'h4, 32'h2); rd(4'h4, v); check("R11 clear done", v, 32'h0);
            check("R12 irq after clear", 32'(irq), 0);
        end

        // R10: start and writes while busy ignored
        stall = 3'b010;
        wr(4'h8, 32'h0); wr(4'hC, 32'h8);
        t0 = txcnt; r0 = rxidx;
        wr(4'h0, 32'h1);
        wr(4'h0, 32'h7);
        wr(4'h8, 32'h80);
        wr(4'hC, 32'h2);
        rd(4'h0, v); check("R10 ctrl unchanged while busy", v, 32'h0);
        wait_idle();
        check("R10 direction kept", 32'(txcnt - t0), 32'h8);
        check("R10 no intake", 32'(rxidx - r0), 0);
        rd(4'h8, v); check("R10 address run kept", v, 32'h20);
        check("R10 irq enable not taken", 32'(irq), 0);
        wr(4'h4, 32'h2);

        // R9: zero-length start
        stall = 3'b000;
        q0 = reqcnt;
        wr(4'h8, 32'h40); wr(4'hC, 32'h0);
        wr(4'h0, 32'h5);
        rd(4'h4, v); check("R9 done at once", v, 32'h2);
        check("R9 irq", 32'(irq), 1);
        check("R9 no memory access", 32'(reqcnt - q0), 0);
        rd(4'h8, v); check("R9 address untouched", v, 32'h40);
        wr(4'h4, 32'h2);
        rd(4'h4, v); check("R11 clear after zero run", v, 32'h0);
    endtask

    initial begin
        fork
            main_tests();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule